// File: doc/BRIEF.md
# Two-Flag Byte ALU

This block is the execute stage of a small load-store controller. It takes an operation code and two byte operands that have already been chosen from the register file or from an immediate. In the same cycle it returns a result and a write-enable for the destination register. On the next rising clock edge it updates its own zero flag and carry flag. The carry that add-with-carry, subtract-with-borrow and the rotates through carry consume is the block's own registered carry. No carry input is taken from outside.

The block has two flags and no shifter. Each class of operation changes a fixed subset of the flags. Compare and test compute flags only and hold the write-enable low. A program gets a shift by clearing or setting carry and then rotating through it. Bitwise NOT is an XOR with all ones. Opcodes 17 to 31 are treated as no-ops.

Top module: `zc_alu`

## Requirements
- R1: While reset (`rst_n` low) is applied, and right after it is released, `zf` and `cf` are both 0.
- R2: ADD (op 0) and ADDC (op 1) write `opa + opb`, plus `cf` for ADDC, modulo 256 with `res_we` = 1. On the next edge `cf` takes the carry out of bit 7 and `zf` takes whether the written result is zero.
- R3: SUB (op 2) and SUBB (op 3) write `opa - opb`, minus `cf` for SUBB, modulo 256 with `res_we` = 1. On the next edge `cf` becomes 1 exactly when unsigned `opa` < `opb` + borrow-in, and `zf` takes whether the result is zero.
- R4: CMP (op 4) updates `zf` and `cf` exactly as SUB would and holds `res_we` at 0.
- R5: AND (op 5), OR (op 6) and XOR (op 7) write the bitwise result with `res_we` = 1 and update `zf` from it. `cf` is left unchanged.
- R6: TEST (op 8) sets `zf` when `opa & opb` is zero, holds `res_we` at 0 and leaves `cf` unchanged.
- R7: ROL (op 9) writes `opa` rotated left by one (bit 7 goes to bit 0). ROR (op 10) writes `opa` rotated right by one (bit 0 goes to bit 7). Both update `zf` from the result and leave `cf` unchanged.
- R8: ROLC (op 11) writes `{opa[6:0], cf}` and loads `opa[7]` into `cf`. RORC (op 12) writes `{cf, opa[7:1]}` and loads `opa[0]` into `cf`. Both update `zf` from the result.
- R9: SETC (op 13), CLRC (op 14), SETZ (op 15) and CLRZ (op 16) force only the named flag to 1 or 0. The other flag is kept and `res_we` is 0.
- R10: Opcodes 17 to 31 hold `res_we` at 0 and leave both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of both flags |
| op | input | 5 | Operation code |
| opa | input | 8 | First operand (destination register value) |
| opb | input | 8 | Second operand (register or immediate) |
| res | output | 8 | Combinational result |
| res_we | output | 1 | Result writeback enable |
| zf | output | 1 | Registered zero flag |
| cf | output | 1 | Registered carry / borrow flag |

## Verification
The bench aims at the carry edges of the arithmetic: 0xFF + 1 with and without carry-in, and a subtraction whose borrow-in turns an equal pair into a borrow. A design that drops the carry-in, or that reports carry rather than borrow, gets these flags wrong. It also chains rotates through carry after explicit set and clear. A design that uses its own out-bit as the fill, or that lets plain rotates touch carry, then writes the wrong bit. Compare, test, the flag operations and the undefined opcodes are interleaved with operations that carry a live flag. A block that writes back on these operations, or that disturbs the flag it should leave alone, shows it on `res_we` or on the flag the next instruction reads.

// File: rtl/zc_alu_pkg.sv
package zc_alu_pkg;

   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 5'd0,
      OP_ADDC = 5'd1,
      OP_SUB  = 5'd2,
      OP_SUBB = 5'd3,
      OP_CMP  = 5'd4,
      OP_AND  = 5'd5,
      OP_OR   = 5'd6,
      OP_XOR  = 5'd7,
      OP_TEST = 5'd8,
      OP_ROL  = 5'd9,
      OP_ROR  = 5'd10,
      OP_ROLC = 5'd11,
      OP_RORC = 5'd12,
      OP_SETC = 5'd13,
      OP_CLRC = 5'd14,
      OP_SETZ = 5'd15,
      OP_CLRZ = 5'd16
   } opcode_e;

   // which datapath unit drives the result
   typedef enum logic [1:0] {
      SRC_ARITH = 2'd0,
      SRC_LOGIC = 2'd1,
      SRC_ROT   = 2'd2,
      SRC_NONE  = 2'd3
   } src_e;

   // where the next carry comes from
   typedef enum logic [1:0] {
      CSRC_ARITH = 2'd0,
      CSRC_ROT   = 2'd1,
      CSRC_ONE   = 2'd2,
      CSRC_ZERO  = 2'd3
   } csrc_e;

   typedef enum logic [1:0] {
      LG_AND = 2'd0,
      LG_OR  = 2'd1,
      LG_XOR = 2'd2
   } logic_e;

endpackage

// File: rtl/zc_alu_arith.sv
module zc_alu_arith #(
   parameter int DATA_W     = 8,
   parameter bit RIPPLE_ADD = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sub,
   input  logic              use_cf,
   input  logic              cf_in,
   output logic [DATA_W-1:0] sum,
   output logic              cy_out
);
   logic [DATA_W-1:0] b_eff;
   logic              c_link;
   logic              raw_co;

   // subtraction is a + ~b + 1 - borrow; the adder carry is the inverse of borrow
   assign b_eff  = sub ? ~b : b;
   assign c_link = sub ? ~(use_cf & cf_in) : (use_cf & cf_in);

   generate
      if (RIPPLE_ADD) begin : g_ripple
         logic [DATA_W:0] chain;
         assign chain[0] = c_link;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign sum[i]     = a[i] ^ b_eff[i] ^ chain[i];
            assign chain[i+1] = (a[i] & b_eff[i]) | (chain[i] & (a[i] ^ b_eff[i]));
         end
         assign raw_co = chain[DATA_W];
      end else begin : g_behav
         logic [DATA_W:0] wide;
         assign wide   = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_link};
         assign sum    = wide[DATA_W-1:0];
         assign raw_co = wide[DATA_W];
      end
   endgenerate

   assign cy_out = sub ? ~raw_co : raw_co;

endmodule

// File: rtl/zc_alu_logic.sv
module zc_alu_logic #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0]      a,
   input  logic [DATA_W-1:0]      b,
   input  zc_alu_pkg::logic_e     fn,
   output logic [DATA_W-1:0]      y
);
   import zc_alu_pkg::*;

   always_comb begin
      unique case (fn)
         LG_AND:  y = a & b;
         LG_OR:   y = a | b;
         LG_XOR:  y = a ^ b;
         default: y = a & b;
      endcase
   end

endmodule

// File: rtl/zc_alu_rot.sv
module zc_alu_rot #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic              left,
   input  logic              thru,
   input  logic              cf_in,
   output logic [DATA_W-1:0] y,
   output logic              out_bit
);
   logic [DATA_W-1:0] y_l;
   logic [DATA_W-1:0] y_r;
   logic              fill_l;
   logic              fill_r;

   assign fill_l = thru ? cf_in : a[DATA_W-1];
   assign fill_r = thru ? cf_in : a[0];

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_lane
         if (i == 0) begin : g_lsb
            assign y_l[i] = fill_l;
         end else begin : g_lmid
            assign y_l[i] = a[i-1];
         end
         if (i == DATA_W-1) begin : g_msb
            assign y_r[i] = fill_r;
         end else begin : g_rmid
            assign y_r[i] = a[i+1];
         end
      end
   endgenerate

   assign y       = left ? y_l : y_r;
   assign out_bit = left ? a[DATA_W-1] : a[0];

endmodule

// File: rtl/zc_alu_flags.sv
module zc_alu_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic z_we,
   input  logic z_d,
   input  logic c_we,
   input  logic c_d,
   output logic zf,
   output logic cf
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zf <= 1'b0;
         cf <= 1'b0;
      end else begin
         if (z_we) zf <= z_d;
         if (c_we) cf <= c_d;
      end
   end

   // R1: flags are clear on the first edge after reset
   a_r1_reset_clear: assert property (@(posedge clk) $rose(rst_n) |-> (!zf && !cf));

endmodule

// File: rtl/zc_alu.sv
module zc_alu #(
   parameter int DATA_W     = 8,
   parameter bit RIPPLE_ADD = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [zc_alu_pkg::OP_W-1:0] op,
   input  logic [DATA_W-1:0]          opa,
   input  logic [DATA_W-1:0]          opb,
   output logic [DATA_W-1:0]          res,
   output logic                       res_we,
   output logic                       zf,
   output logic                       cf
);
   import zc_alu_pkg::*;

   localparam logic [DATA_W-1:0] ZERO_W = '0;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("zc_alu: DATA_W must be at least 2");
      end
   endgenerate

   opcode_e opc;
   assign opc = opcode_e'(op);

   // decode
   logic   d_sub, d_use_cf, d_left, d_thru;
   logic   d_z_we, d_c_we, d_z_force, d_z_fval;
   src_e   d_src;
   csrc_e  d_csrc;
   logic_e d_lfn;
   logic   d_we;

   always_comb begin
      d_sub     = 1'b0;
      d_use_cf  = 1'b0;
      d_left    = 1'b1;
      d_thru    = 1'b0;
      d_z_we    = 1'b0;
      d_c_we    = 1'b0;
      d_z_force = 1'b0;
      d_z_fval  = 1'b0;
      d_src     = SRC_NONE;
      d_csrc    = CSRC_ARITH;
      d_lfn     = LG_AND;
      d_we      = 1'b0;
      case (opc)
         OP_ADD, OP_ADDC: begin
            d_src = SRC_ARITH; d_use_cf = (opc == OP_ADDC);
            d_we = 1'b1; d_z_we = 1'b1; d_c_we = 1'b1;
         end
         OP_SUB, OP_SUBB, OP_CMP: begin
            d_src = SRC_ARITH; d_sub = 1'b1; d_use_cf = (opc == OP_SUBB);
            d_we = (opc != OP_CMP); d_z_we = 1'b1; d_c_we = 1'b1;
         end
         OP_AND, OP_TEST: begin
            d_src = SRC_LOGIC; d_lfn = LG_AND;
            d_we = (opc == OP_AND); d_z_we = 1'b1;
         end
         OP_OR: begin
            d_src = SRC_LOGIC; d_lfn = LG_OR; d_we = 1'b1; d_z_we = 1'b1;
         end
         OP_XOR: begin
            d_src = SRC_LOGIC; d_lfn = LG_XOR; d_we = 1'b1; d_z_we = 1'b1;
         end
         OP_ROL, OP_ROR: begin
            d_src = SRC_ROT; d_left = (opc == OP_ROL);
            d_we = 1'b1; d_z_we = 1'b1;
         end
         OP_ROLC, OP_RORC: begin
            d_src = SRC_ROT; d_left = (opc == OP_ROLC); d_thru = 1'b1;
            d_we = 1'b1; d_z_we = 1'b1; d_c_we = 1'b1; d_csrc = CSRC_ROT;
         end
         OP_SETC: begin d_c_we = 1'b1; d_csrc = CSRC_ONE;  end
         OP_CLRC: begin d_c_we = 1'b1; d_csrc = CSRC_ZERO; end
         OP_SETZ: begin d_z_we = 1'b1; d_z_force = 1'b1; d_z_fval = 1'b1; end
         OP_CLRZ: begin d_z_we = 1'b1; d_z_force = 1'b1; d_z_fval = 1'b0; end
         default: ;
      endcase
   end

   // datapath units
   logic [DATA_W-1:0] ar_y, lg_y, rt_y;
   logic              ar_c, rt_c;

   zc_alu_arith #(.DATA_W(DATA_W), .RIPPLE_ADD(RIPPLE_ADD)) u_arith (
      .a(opa), .b(opb), .sub(d_sub), .use_cf(d_use_cf), .cf_in(cf),
      .sum(ar_y), .cy_out(ar_c)
   );

   zc_alu_logic #(.DATA_W(DATA_W)) u_logic (
      .a(opa), .b(opb), .fn(d_lfn), .y(lg_y)
   );

   zc_alu_rot #(.DATA_W(DATA_W)) u_rot (
      .a(opa), .left(d_left), .thru(d_thru), .cf_in(cf),
      .y(rt_y), .out_bit(rt_c)
   );

   logic [DATA_W-1:0] val;
   always_comb begin
      unique case (d_src)
         SRC_ARITH: val = ar_y;
         SRC_LOGIC: val = lg_y;
         SRC_ROT:   val = rt_y;
         default:   val = ZERO_W;
      endcase
   end

   assign res    = val;
   assign res_we = d_we;

   logic z_next, c_next;
   assign z_next = d_z_force ? d_z_fval : (val == ZERO_W);

   always_comb begin
      unique case (d_csrc)
         CSRC_ARITH: c_next = ar_c;
         CSRC_ROT:   c_next = rt_c;
         CSRC_ONE:   c_next = 1'b1;
         default:    c_next = 1'b0;
      endcase
   end

   zc_alu_flags u_flags (
      .clk(clk), .rst_n(rst_n),
      .z_we(d_z_we), .z_d(z_next), .c_we(d_c_we), .c_d(c_next),
      .zf(zf), .cf(cf)
   );

   // R2: every written result leaves zf reflecting that result
   a_r2_zero_tracks_write: assert property (@(posedge clk) disable iff (!rst_n)
      res_we |=> (zf == ($past(res) == ZERO_W)));

   // R4: compare borrow equals an unsigned less-than of the operands
   a_r4_cmp_borrow: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_CMP) |=> (cf == ($past(opa) < $past(opb))));

   // R4: compare never writes
   a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_CMP) |-> !res_we);

   // R5, R6: logic class leaves carry alone
   a_r5_logic_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_TEST) |=> (cf == $past(cf)));

   // R8: rotate-left through carry captures the top bit
   a_r8_rolc_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ROLC) |=> (cf == $past(opa[DATA_W-1])));

   // R9: set-carry forces carry and keeps zero
   a_r9_setc: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SETC) |=> (cf && zf == $past(zf)));

   // R10: undefined opcodes are inert
   a_r10_undef_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (op > 5'd16) |=> (zf == $past(zf) && cf == $past(cf)));

endmodule

// File: tb/zc_alu_test.sv
`timescale 1ns/1ps
module zc_alu_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] op = 5'd31;
   logic [7:0] opa = 8'h00, opb = 8'h00;
   logic [7:0] res;
   logic       res_we, zf, cf;

   int total = 0;
   int bad = 0;
   int mz = 0, mc = 0;   // model flags

   always #2 clk = ~clk;  // 250 MHz

   zc_alu uut (
      .clk(clk), .rst_n(rst_n), .op(op), .opa(opa), .opb(opb),
      .res(res), .res_we(res_we), .zf(zf), .cf(cf)
   );

   function automatic string tag_of(int o);
      if (o <= 1)  return "R2";
      if (o <= 3)  return "R3";
      if (o == 4)  return "R4";
      if (o <= 7)  return "R5";
      if (o == 8)  return "R6";
      if (o <= 10) return "R7";
      if (o <= 12) return "R8";
      if (o <= 16) return "R9";
      return "R10";
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // behavioural reference: returns expected result and write, updates model flags
   task automatic step(int o, int a, int b);
      int r, we, nz, nc, t;
      @(negedge clk);
      op = o[4:0]; opa = a[7:0]; opb = b[7:0];
      #1;
      r = 0; we = 0; nz = mz; nc = mc;
      case (o)
         0, 1: begin t = a + b + ((o == 1) ? mc : 0); r = t % 256; we = 1; nc = (t > 255); nz = (r == 0); end
         2, 3, 4: begin
            t = a - b - ((o == 3) ? mc : 0);
            nc = (t < 0); r = (t + 512) % 256; we = (o != 4); nz = (r == 0);
         end
         5: begin r = a & b; we = 1; nz = (r == 0); end
         6: begin r = a | b; we = 1; nz = (r == 0); end
         7: begin r = a ^ b; we = 1; nz = (r == 0); end
         8: begin r = a & b; nz = (r == 0); end
         9:  begin r = ((a * 2) % 256) + (a / 128); we = 1; nz = (r == 0); end
         10: begin r = (a / 2) + (a % 2) * 128; we = 1; nz = (r == 0); end
         11: begin r = ((a * 2) % 256) + mc; we = 1; nc = a / 128; nz = (r == 0); end
         12: begin r = (a / 2) + mc * 128; we = 1; nc = a % 2; nz = (r == 0); end
         13: nc = 1;
         14: nc = 0;
         15: nz = 1;
         16: nz = 0;
         default: ;
      endcase
      chk(tag_of(o), "res_we", int'(res_we), we);
      if (we != 0) chk(tag_of(o), "res", int'(res), r);
      chk(tag_of(o), "zf(prior)", int'(zf), mz);
      chk(tag_of(o), "cf(prior)", int'(cf), mc);
      mz = nz; mc = nc;
   endtask

   initial begin
      #(200000 * 4);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1", "zf in reset", int'(zf), 0);
      chk("R1", "cf in reset", int'(cf), 0);
      @(negedge clk); rst_n = 1'b1;
      step(31, 0, 0);                 // R1 flags after release
      // R2 carry corners
      step(0, 8'hFF, 8'h01);
      step(1, 8'h00, 8'h00);          // carry-in gives 1
      step(13, 0, 0);
      step(1, 8'hFF, 8'h00);          // 0xFF + 0 + 1 wraps
      step(0, 8'h12, 8'h34);
      // R3 borrow corners
      step(13, 0, 0);
      step(3, 8'h05, 8'h05);          // equal pair with borrow-in
      step(2, 8'h05, 8'h05);
      step(3, 8'h00, 8'hFF);
      step(2, 8'h80, 8'h01);
      // R4 compare
      step(4, 8'h10, 8'h20);
      step(4, 8'h20, 8'h20);
      // R5 logic keeps carry, R6 test
      step(13, 0, 0);
      step(7, 8'hA5, 8'hFF);          // NOT via XOR
      step(5, 8'hF0, 8'h0F);
      step(6, 8'h00, 8'h00);
      step(8, 8'h80, 8'h7F);
      step(8, 8'h81, 8'h01);
      // R7 plain rotates
      step(14, 0, 0);
      step(9, 8'h81, 0);
      step(10, 8'h01, 0);
      step(13, 0, 0);
      step(9, 8'h00, 0);
      // R8 rotates through carry (shift emulation)
      step(14, 0, 0);
      step(11, 8'h80, 0);
      step(11, 8'h00, 0);
      step(12, 8'h01, 0);
      step(12, 8'h00, 0);
      step(13, 0, 0);
      step(12, 8'h00, 0);
      // R9 flag ops
      step(15, 0, 0);
      step(14, 0, 0);
      step(16, 0, 0);
      step(13, 0, 0);
      step(15, 0, 0);
      // R10 undefined opcodes
      for (int u = 17; u < 32; u++) step(u, 8'h00, 8'h00);
      // mixed sweep
      for (int i = 0; i < 3000; i++) begin
         int o;
         o = (i % 8 == 7) ? int'($urandom_range(31, 13)) : int'($urandom_range(12, 0));
         step(o, int'($urandom_range(255, 0)), int'($urandom_range(255, 0)));
      end
      step(31, 0, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule